// File: doc/BRIEF.md
# UART FIFO Ready and Interrupt Controller

This block holds the byte FIFO pair for one UART channel, one FIFO for transmit and one for receive, each 16 entries deep. It decodes a byte-wide control write that turns the FIFOs on, flushes them, picks the receive trigger level and selects one of two ready-signalling modes. It drives active-low transmit-ready and receive-ready strobes for a DMA engine, and a transmit and a receive interrupt request. The host side pushes and pops each FIFO through simple strobes. Serial shifting, baud timing, modem lines and line status belong to other blocks.

The two ready modes use different thresholds. In the single-character mode, transmit-ready is asserted only while the transmit side holds nothing, and receive-ready is asserted while the receive side holds anything. In the block mode, transmit-ready is asserted while any transmit slot is free, and receive-ready is asserted once the receive fill reaches the programmed trigger level. The receive-ready strobe leaves the block on a shared multi-function pin, and only when a 2-bit pin-function select picks it.

Top module: `uart_fifo_dma_ctrl`

## Requirements
- R1: After reset both FIFOs are empty, the control readback is 0x00, `txrdy_n` is 0, `tx_irq` is 1, `rx_irq` is 0 and `rx_overrun` is 0.
- R2: A write to the control register stores bit 0 (FIFO enable), bit 3 (block mode) and bits 7:6 (trigger code). The readback shows these bits in the same positions, and bits 5:4 and 2:1 always read as 0.
- R3: With FIFOs enabled, each FIFO holds up to 16 bytes in first-in first-out order. The head byte is shown on the data output while the FIFO is not empty. A push into a full FIFO is dropped. A push and a pop in the same cycle are both honoured, and the push capacity is judged on the count before that cycle.
- R4: With FIFOs disabled (bit 0 = 0), each FIFO holds a single byte, and a second push before a pop is dropped.
- R5: A pop from an empty FIFO leaves it empty, and the data output reads 0 while a FIFO is empty.
- R6: A control write with bit 1 = 1 flushes the receive FIFO and one with bit 2 = 1 flushes the transmit FIFO, at the edge that takes the write. A push in that cycle to a flushed FIFO is lost. A write that changes bit 0 flushes both FIFOs.
- R7: In single-character mode (bit 3 = 0 or FIFOs disabled), `txrdy_n` is 0 exactly when the transmit FIFO is empty.
- R8: In single-character mode, the receive-ready level is 0 exactly when the receive FIFO holds at least one byte.
- R9: In block mode with FIFOs enabled, `txrdy_n` is 0 while at least one transmit slot is free. In every mode `tx_irq` is the inverse of `txrdy_n`.
- R10: Trigger codes 00, 01, 10 and 11 mean 1, 4, 8 and 14 bytes. With FIFOs enabled, `rx_irq` is 1 when the receive count is at or above the trigger level. With FIFOs disabled, `rx_irq` is 1 when the holding byte is present. In block mode the receive-ready level is 0 when the count is at or above the trigger level.
- R11: A receive push that is dropped because the FIFO is full sets `rx_overrun`. The flag stays set until reset.
- R12: `mf_out` carries the receive-ready level when `mf_sel` = 01, and is 1 for every other `mf_sel` value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register readback |
| mf_sel | input | 2 | Multi-function pin select |
| tx_push | input | 1 | Host writes a byte into the transmit FIFO |
| tx_din | input | 8 | Transmit write data |
| tx_pop | input | 1 | Transmitter takes the head byte |
| tx_dout | output | 8 | Transmit head byte, 0 when empty |
| rx_push | input | 1 | Receiver delivers a byte |
| rx_din | input | 8 | Receive write data |
| rx_pop | input | 1 | Host reads the head byte |
| rx_dout | output | 8 | Receive head byte, 0 when empty |
| txrdy_n | output | 1 | Active-low transmit DMA ready |
| mf_out | output | 1 | Multi-function pin, receive-ready when selected |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_irq | output | 1 | Receive interrupt request |
| rx_overrun | output | 1 | Sticky receive overrun flag |

## Verification
The main stimulus is a long run of random pushes, pops, control writes and pin-select values, compared each cycle against a queue-based model. This run covers both ready modes, all four trigger codes and the enabled and disabled FIFO configurations. Directed sequences then fill the transmit FIFO past 16 to separate the two transmit thresholds, step the receive fill across a trigger of 8 to tell "at level" from "below", and push twice with FIFOs disabled to tell single-entry depth from full depth. Flush writes with a push in the same cycle show that the clear wins, and a pop on an empty FIFO shows that it does not disturb the count.

// File: rtl/ufd_pkg.sv
package ufd_pkg;
  localparam int DATA_W = 8;
  localparam int FIFO_DEPTH = 16;
  localparam logic [1:0] MF_RXRDY = 2'b01;

  typedef struct packed {
    logic [1:0] trig;
    logic       blk_mode;
    logic       fifo_en;
  } cfg_t;

  function automatic int trig_chars(input logic [1:0] code);
    case (code)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction
endpackage

// File: rtl/ufd_ctrl_reg.sv
module ufd_ctrl_reg
  import ufd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output cfg_t              cfg,
  output logic              tx_flush,
  output logic              rx_flush,
  output logic [DATA_W-1:0] rdback
);
  cfg_t cfg_q, cfg_d;
  logic en_change;

  assign en_change = we && (wdata[0] != cfg_q.fifo_en);

  always_comb begin
    cfg_d = cfg_q;
    if (we) begin
      cfg_d.fifo_en  = wdata[0];
      cfg_d.blk_mode = wdata[3];
      cfg_d.trig     = wdata[7:6];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign tx_flush = (we && wdata[2]) || en_change;
  assign rx_flush = (we && wdata[1]) || en_change;
  assign cfg      = cfg_q;
  assign rdback   = {cfg_q.trig, 2'b00, cfg_q.blk_mode, 2'b00, cfg_q.fifo_en};

  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(cfg_q));
endmodule

// File: rtl/ufd_byte_fifo.sv
module ufd_byte_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          single,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] count,
  output logic          dropped
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d, lim;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign lim     = single ? CW'(1) : CW'(DEPTH);
  assign do_push = push && !flush && (cnt_q < lim);
  assign do_pop  = pop && !flush && (cnt_q != '0);
  assign dropped = push && !flush && (cnt_q >= lim);

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wr_d = bump(wr_q);
      if (do_pop)  rd_d = bump(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din;
  end

  assign dout  = (cnt_q != '0) ? mem[rd_q] : '0;
  assign count = cnt_q;

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  p_single_depth_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (single && !flush && $stable(single)) |-> cnt_q <= CW'(1));
  p_empty_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && cnt_q == '0) |=> cnt_q == '0);
  p_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> cnt_q == '0);
endmodule

// File: rtl/ufd_ready.sv
module ufd_ready
  import ufd_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cfg_t          cfg,
  input  logic [CW-1:0] tx_cnt,
  input  logic [CW-1:0] rx_cnt,
  output logic          txrdy_n,
  output logic          rxrdy_n,
  output logic          tx_irq,
  output logic          rx_irq
);
  logic          block;
  logic [CW-1:0] trig_lvl;
  logic          at_trig;

  assign block    = cfg.fifo_en && cfg.blk_mode;
  assign trig_lvl = CW'(trig_chars(cfg.trig));
  assign at_trig  = cfg.fifo_en ? (rx_cnt >= trig_lvl) : (rx_cnt != '0);

  always_comb begin
    if (block) begin
      txrdy_n = (tx_cnt == CW'(DEPTH));
      rxrdy_n = !at_trig;
    end else begin
      txrdy_n = (tx_cnt != '0);
      rxrdy_n = (rx_cnt == '0);
    end
    tx_irq = !txrdy_n;
    rx_irq = at_trig;
  end

  p_tx_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!block && tx_cnt == '0) |-> !txrdy_n);
  p_rx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!block && rx_cnt != '0) |-> !rxrdy_n);
  p_tx_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (block && tx_cnt == CW'(DEPTH)) |-> (txrdy_n && !tx_irq));
  p_rx_below_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.fifo_en && rx_cnt == '0) |-> !rx_irq);
endmodule

// File: rtl/uart_fifo_dma_ctrl.sv
module uart_fifo_dma_ctrl
  import ufd_pkg::*;
#(
  parameter int DEPTH = FIFO_DEPTH,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic [1:0]        mf_sel,
  input  logic              tx_push,
  input  logic [DATA_W-1:0] tx_din,
  input  logic              tx_pop,
  output logic [DATA_W-1:0] tx_dout,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_din,
  input  logic              rx_pop,
  output logic [DATA_W-1:0] rx_dout,
  output logic              txrdy_n,
  output logic              mf_out,
  output logic              tx_irq,
  output logic              rx_irq,
  output logic              rx_overrun
);
  logic [1:0]    rst_pipe;
  logic          rst_sync_n;
  cfg_t          cfg;
  logic          tx_flush, rx_flush;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          tx_drop, rx_drop, rxrdy_n;
  logic          ovr_q, ovr_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  ufd_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .we(cfg_we), .wdata(cfg_wdata),
    .cfg(cfg), .tx_flush(tx_flush), .rx_flush(rx_flush), .rdback(cfg_rdata)
  );

  ufd_byte_fifo #(.DW(DATA_W), .DEPTH(DEPTH)) u_txf (
    .clk(clk), .rst_n(rst_sync_n), .single(!cfg.fifo_en), .flush(tx_flush),
    .push(tx_push), .din(tx_din), .pop(tx_pop), .dout(tx_dout),
    .count(tx_cnt), .dropped(tx_drop)
  );

  ufd_byte_fifo #(.DW(DATA_W), .DEPTH(DEPTH)) u_rxf (
    .clk(clk), .rst_n(rst_sync_n), .single(!cfg.fifo_en), .flush(rx_flush),
    .push(rx_push), .din(rx_din), .pop(rx_pop), .dout(rx_dout),
    .count(rx_cnt), .dropped(rx_drop)
  );

  ufd_ready #(.DEPTH(DEPTH)) u_rdy (
    .clk(clk), .rst_n(rst_sync_n), .cfg(cfg), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
    .txrdy_n(txrdy_n), .rxrdy_n(rxrdy_n), .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  assign ovr_d = ovr_q || rx_drop;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ovr_q <= 1'b0;
    else             ovr_q <= ovr_d;
  end

  assign rx_overrun = ovr_q;
  assign mf_out     = (mf_sel == MF_RXRDY) ? rxrdy_n : 1'b1;

  p_ovr_set_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rx_drop |=> rx_overrun);
  p_ovr_sticky_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rx_overrun |=> rx_overrun);
  p_mf_idle_r12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mf_sel != MF_RXRDY) |-> mf_out);
  p_tx_nodrop_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tx_push && !tx_flush && tx_cnt == '0) |-> !tx_drop);
endmodule

// File: tb/sim_uart_fifo_dma_ctrl.sv
`timescale 1ns/1ps
module sim_uart_fifo_dma_ctrl;
  logic clk = 1'b0;
  logic rst_n;
  logic cfg_we;
  logic [7:0] cfg_wdata, cfg_rdata;
  logic [1:0] mf_sel;
  logic tx_push, tx_pop, rx_push, rx_pop;
  logic [7:0] tx_din, rx_din, tx_dout, rx_dout;
  logic txrdy_n, mf_out, tx_irq, rx_irq, rx_overrun;

  always #2.5 clk = ~clk;

  uart_fifo_dma_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .mf_sel(mf_sel), .tx_push(tx_push), .tx_din(tx_din),
    .tx_pop(tx_pop), .tx_dout(tx_dout), .rx_push(rx_push), .rx_din(rx_din),
    .rx_pop(rx_pop), .rx_dout(rx_dout), .txrdy_n(txrdy_n), .mf_out(mf_out),
    .tx_irq(tx_irq), .rx_irq(rx_irq), .rx_overrun(rx_overrun)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int txq[$];
  int rxq[$];
  bit m_en, m_blk, m_ovr;
  bit [1:0] m_trig;

  function automatic int trig_of(bit [1:0] t);
    case (t)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  function automatic int exp_txrdy();
    if (m_en && m_blk) return (txq.size() == 16) ? 1 : 0;
    return (txq.size() != 0) ? 1 : 0;
  endfunction

  function automatic int exp_rxirq();
    if (m_en) return (rxq.size() >= trig_of(m_trig)) ? 1 : 0;
    return (rxq.size() != 0) ? 1 : 0;
  endfunction

  function automatic int exp_rxrdy();
    if (m_en && m_blk) return exp_rxirq() ? 0 : 1;
    return (rxq.size() == 0) ? 1 : 0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_update();
    bit ftx = 0, frx = 0;
    int txc = txq.size();
    int rxc = rxq.size();
    int lim = m_en ? 16 : 1;
    if (cfg_we) begin
      if (cfg_wdata[0] != m_en) begin ftx = 1; frx = 1; end
      if (cfg_wdata[1]) frx = 1;
      if (cfg_wdata[2]) ftx = 1;
    end
    if (ftx) txq.delete();
    else begin
      if (tx_pop && txc > 0) void'(txq.pop_front());
      if (tx_push && txc < lim) txq.push_back(int'(tx_din));
    end
    if (frx) rxq.delete();
    else begin
      if (rx_pop && rxc > 0) void'(rxq.pop_front());
      if (rx_push && rxc < lim) rxq.push_back(int'(rx_din));
      if (rx_push && rxc >= lim) m_ovr = 1;
    end
    if (cfg_we) begin
      m_en = cfg_wdata[0];
      m_blk = cfg_wdata[3];
      m_trig = cfg_wdata[7:6];
    end
  endtask

  task automatic compare_all();
    bit blk = m_en && m_blk;
    int rr = exp_rxrdy();
    chk(blk ? "R9 txrdy_n" : "R7 txrdy_n", int'(txrdy_n), exp_txrdy());
    chk("R9 tx_irq", int'(tx_irq), 1 - exp_txrdy());
    chk("R10 rx_irq", int'(rx_irq), exp_rxirq());
    chk(blk ? "R10 mf_out" : "R8 mf_out", int'(mf_out), (mf_sel == 2'b01) ? rr : 1);
    chk("R3 tx_dout", int'(tx_dout), txq.size() ? txq[0] : 0);
    chk("R3 rx_dout", int'(rx_dout), rxq.size() ? rxq[0] : 0);
    chk("R2 cfg_rdata", int'(cfg_rdata), int'({m_trig, 2'b00, m_blk, 2'b00, m_en}));
    chk("R11 rx_overrun", int'(rx_overrun), int'(m_ovr));
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare_all();
    cfg_we = 0; tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
  endtask

  task automatic wr_cfg(bit [7:0] v);
    cfg_we = 1; cfg_wdata = v; step();
  endtask

  task automatic push_rx(bit [7:0] v);
    rx_push = 1; rx_din = v; step();
  endtask

  task automatic push_tx(bit [7:0] v);
    tx_push = 1; tx_din = v; step();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_2552));
    rst_n = 0; cfg_we = 0; cfg_wdata = 0; mf_sel = 2'b01;
    tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0; tx_din = 0; rx_din = 0;
    m_en = 0; m_blk = 0; m_ovr = 0; m_trig = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 txrdy_n", int'(txrdy_n), 0);
    chk("R1 tx_irq", int'(tx_irq), 1);
    chk("R1 rx_irq", int'(rx_irq), 0);
    chk("R1 rx_overrun", int'(rx_overrun), 0);
    chk("R1 cfg_rdata", int'(cfg_rdata), 0);
    chk("R1 mf_out", int'(mf_out), 1);

    // R4 disabled: single entry, second push dropped
    push_rx(8'hA1);
    push_rx(8'hB2);
    chk("R4 head", int'(rx_dout), 8'hA1);
    rx_pop = 1; step();
    chk("R4 empty after one pop", int'(mf_out), 1);
    // R5 pop from empty
    rx_pop = 1; step();
    chk("R5 empty dout", int'(rx_dout), 0);
    push_rx(8'h33);
    chk("R5 count intact", int'(rx_dout), 8'h33);

    // R2 readback masks, enable change flushes (R6)
    wr_cfg(8'hFF);
    chk("R2 readback", int'(cfg_rdata), 8'hC9);
    chk("R6 flush on enable", int'(rx_dout), 0);

    // R3/R9 fill transmit past 16 in block mode
    for (int i = 0; i < 17; i++) push_tx(8'(i + 16));
    chk("R9 full txrdy_n", int'(txrdy_n), 1);
    tx_pop = 1; step();
    chk("R9 one free slot", int'(txrdy_n), 0);
    chk("R3 order", int'(tx_dout), 17);

    // R6 clear with simultaneous push
    tx_push = 1; tx_din = 8'h77; cfg_we = 1; cfg_wdata = 8'hCD; step();
    chk("R6 tx cleared", int'(tx_dout), 0);

    // R10 trigger 8 in block mode
    wr_cfg(8'h8B);
    for (int i = 0; i < 7; i++) push_rx(8'(i));
    chk("R10 below trigger", int'(rx_irq), 0);
    push_rx(8'h07);
    chk("R10 at trigger", int'(rx_irq), 1);
    chk("R10 mf low", int'(mf_out), 0);
    mf_sel = 2'b10; #1;
    chk("R12 mf not selected", int'(mf_out), 1);

    // R11 overrun in FIFO mode
    for (int i = 0; i < 9; i++) push_rx(8'hE0);
    chk("R11 overrun set", int'(rx_overrun), 1);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      mf_sel = 2'($urandom_range(0, 3));
      tx_push = ($urandom_range(0, 1) == 1);
      tx_din = 8'($urandom);
      tx_pop = ($urandom_range(0, 9) < 3);
      rx_push = ($urandom_range(0, 1) == 1);
      rx_din = 8'($urandom);
      rx_pop = ($urandom_range(0, 9) < 3);
      if ($urandom_range(0, 49) == 0) begin
        cfg_we = 1;
        cfg_wdata = {2'($urandom), 2'($urandom), 1'($urandom),
                     ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0),
                     ($urandom_range(0, 4) != 0)};
      end
      step();
    end
    finish_run();
  end
endmodule